// File: doc/BRIEF.md
# Dual-Format Audio Serial Receiver

This block takes stereo audio from a three-wire serial link (bit clock, frame clock, data) and turns it into parallel 24-bit left and right samples. All logic runs on a system clock that is several times faster than the bit clock. The three serial lines are brought in through two-flop synchronizers, and the bit clock's rising edge is detected in the system clock domain. A static format input picks one of two framings. In the justified framing the first data bit follows a frame-clock change at once. In the I2S framing it comes one bit clock later.

Each channel slot gives at most 24 data bits, sent MSB first as two's complement. Later slots in the same half-frame are not used. A slot shorter than that is filled with zeros in its low bits. After the right word of a frame completes, the left/right pair is offered on a valid/ready output. Back-pressure rule: while `out_valid` is high and `out_ready` is low, the pair on the outputs stays unchanged. A newer pair that completes in that time is discarded, because the serial link cannot be stalled. Change `fmt_sel` only while `rst_n` is low.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is held and right after it ends, `out_valid` is 0 and both sample outputs are 0.
- R2: Each word is 24 bits, two's complement, MSB first. A bit is taken at each synchronized rising edge of `bclk_i`.
- R3: With `fmt_sel`=0, the MSB is the bit at the first bit-clock rise after a frame-clock change. The left channel is the half-frame with the frame clock high.
- R4: With `fmt_sel`=1, the MSB is the bit at the second bit-clock rise after a frame-clock change. The left channel is the half-frame with the frame clock low.
- R5: Bits after the 24th data bit of a half-frame have no effect on the output words. This covers slots of 25 and 32 bit clocks.
- R6: A half-frame with fewer data bits than 24 gives a word whose missing low bits are 0. Example: a 20-clock slot gives 20 bits in justified mode and 19 bits in I2S mode.
- R7: One pair is offered per frame, left before right. The pair is offered after the frame-clock change that ends the right half. No pair comes out unless a full left half was received after reset.
- R8: While `out_valid`=1 and `out_ready`=0, valid stays high and both words stay stable. A pair that completes in that time is dropped.
- R9: A handshake cycle (`out_valid` and `out_ready` both high) with no new pair clears `out_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 1 | 0 = justified framing, 1 = I2S framing (static) |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Serial frame clock |
| sdata_i | input | 1 | Serial data |
| out_ready | input | 1 | Sink accepts the pair this cycle |
| out_valid | output | 1 | A pair is held on the outputs |
| out_left | output | 24 | Left sample |
| out_right | output | 24 | Right sample |

## Verification
The assertions assume the following about the inputs. Each bit-clock level lasts long enough for the synchronizers to see it. The frame clock and the data change only while the bit clock is low. So one detected rise never sees a half-changed frame clock, and two pair strobes can never fall on neighbouring cycles. The stimulus meets this by holding each bit-clock level for three system clocks. It sets the frame clock and data at the start of the low phase, and it changes `out_ready` away from the system clock edge. The format is changed only inside a reset pulse.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic {FMT_MSBJ = 1'b0, FMT_I2S = 1'b1} fmt_e;

  // frame-clock level that marks the left channel for a framing
  function automatic logic left_level(fmt_e f);
    return (f == FMT_MSBJ);
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] dout
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/slot_capture.sv
module slot_capture
  import aud_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              bclk,
  input  logic              lr,
  input  logic              sd,
  output logic              half_done,
  output logic              half_left,
  output logic [WORD_W-1:0] half_word
);
  localparam int POS_MAX = WORD_W + 1;
  localparam int POS_W   = $clog2(POS_MAX + 1);
  localparam logic [POS_W-1:0] POS_MAX_P = POS_W'(POS_MAX);
  localparam logic [POS_W-1:0] WORD_W_P  = POS_W'(WORD_W);

  logic              bclk_d, seen, armed, lr_prev;
  logic [POS_W-1:0]  pos, pos_n, dly, k;
  logic [WORD_W-1:0] word, word_n;
  logic              rise, chg;

  always_comb begin
    rise   = bclk & ~bclk_d;
    chg    = seen && (lr != lr_prev);
    dly    = (fmt == FMT_I2S) ? POS_W'(1) : POS_W'(0);
    pos_n  = chg ? '0 : ((pos == POS_MAX_P) ? pos : pos + POS_W'(1));
    word_n = chg ? '0 : word;
    k      = pos_n - dly;
    if (pos_n >= dly && k < WORD_W_P)
      word_n[WORD_W-1-int'(k)] = sd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d    <= 1'b0;
      seen      <= 1'b0;
      armed     <= 1'b0;
      lr_prev   <= 1'b0;
      pos       <= POS_MAX_P;
      word      <= '0;
      half_done <= 1'b0;
      half_left <= 1'b0;
      half_word <= '0;
    end else begin
      bclk_d    <= bclk;
      half_done <= 1'b0;
      if (rise) begin
        if (!seen) begin
          seen    <= 1'b1;
          lr_prev <= lr;
          pos     <= POS_MAX_P;
          word    <= '0;
        end else begin
          pos  <= pos_n;
          word <= word_n;
          if (chg) begin
            lr_prev   <= lr;
            armed     <= 1'b1;
            half_done <= armed;
            half_left <= (lr_prev == left_level(fmt));
            half_word <= word;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pair_build.sv
module pair_build #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_done,
  input  logic              half_left,
  input  logic [WORD_W-1:0] half_word,
  output logic              pair_stb,
  output logic [WORD_W-1:0] pair_l,
  output logic [WORD_W-1:0] pair_r
);
  logic              l_ok;
  logic [WORD_W-1:0] l_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_ok     <= 1'b0;
      l_hold   <= '0;
      pair_stb <= 1'b0;
      pair_l   <= '0;
      pair_r   <= '0;
    end else begin
      pair_stb <= 1'b0;
      if (half_done) begin
        if (half_left) begin
          l_hold <= half_word;
          l_ok   <= 1'b1;
        end else if (l_ok) begin
          pair_stb <= 1'b1;
          pair_l   <= l_hold;
          pair_r   <= half_word;
          l_ok     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_sel,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right
);
  logic [2:0]        lines_s;
  logic              half_done, half_left, pair_stb;
  logic [WORD_W-1:0] half_word, pair_l, pair_r;
  fmt_e              fmt;

  assign fmt = fmt_e'(fmt_sel);

  line_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({sdata_i, lrclk_i, bclk_i}),
    .dout (lines_s)
  );

  slot_capture #(.WORD_W(WORD_W)) u_cap (
    .clk (clk),
    .rst_n (rst_n),
    .fmt (fmt),
    .bclk (lines_s[0]),
    .lr (lines_s[1]),
    .sd (lines_s[2]),
    .half_done (half_done),
    .half_left (half_left),
    .half_word (half_word)
  );

  pair_build #(.WORD_W(WORD_W)) u_pair (
    .clk (clk),
    .rst_n (rst_n),
    .half_done (half_done),
    .half_left (half_left),
    .half_word (half_word),
    .pair_stb (pair_stb),
    .pair_l (pair_l),
    .pair_r (pair_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (pair_stb && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_left  <= pair_l;
      out_right <= pair_r;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_left,
  input logic [WORD_W-1:0] out_right,
  input logic              pair_stb
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right))); // R8

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !pair_stb) |=> !out_valid); // R9

  AST_VALID_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pair_stb)); // R7

  AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb); // R7
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left (out_left),
  .out_right (out_right),
  .pair_stb (pair_stb)
);

// File: tb/aud_ser_rx_bench.sv
module aud_ser_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int    n_checks = 0, n_bad = 0;
  int    cycles = 0;
  int    rx_idx = 0;
  string cur_req = "R3";
  logic [23:0] exp_l [0:7];
  logic [23:0] exp_r [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ser_rx u_aud_ser_rx (
    .clk (clk), .rst_n (rst_n), .fmt_sel (fmt_sel),
    .bclk_i (bclk_i), .lrclk_i (lrclk_i), .sdata_i (sdata_i),
    .out_ready (out_ready), .out_valid (out_valid),
    .out_left (out_left), .out_right (out_right)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: a handshake seen at the falling edge is taken at the next rising edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && out_valid && out_ready) begin
      if (rx_idx < 8) begin
        check(out_left == exp_l[rx_idx], {cur_req, " left"}, out_left, exp_l[rx_idx]);
        check(out_right == exp_r[rx_idx], {cur_req, " right"}, out_right, exp_r[rx_idx]);
      end
      rx_idx++;
    end
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic send_slot(input logic lr, input logic d);
    lrclk_i = lr; sdata_i = d; bclk_i = 1'b0;
    repeat (HALF) step();
    bclk_i = 1'b1;
    repeat (HALF) step();
  endtask

  function automatic logic [23:0] pat(input int i, input int ch, input int seed);
    if (i == 0) return ch ? 24'h7FFFFF : 24'h800000;
    if (i == 3) return ch ? 24'h000000 : 24'hFFFFFF;
    return 24'(i * 24'h2B3C5 + ch * 24'h91A7 + seed * 24'h1111 + 24'h5A5A5A);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bclk_i = 1'b0; out_ready = 1'b1;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (2) step();
  endtask

  task automatic run_seq(input logic fmt, input int slots, input int nfr,
                         input int seed, input bit hold, input string req);
    int kept;
    logic [23:0] mask, w;
    logic left_lv, lv, b;
    rst_n = 1'b0;
    fmt_sel = fmt;
    do_reset();
    cur_req = req;
    kept = fmt ? slots - 1 : slots;
    if (kept > 24) kept = 24;
    mask = 24'hFFFFFF << (24 - kept);
    for (int f = 0; f < nfr; f++) begin
      exp_l[f] = pat(f, 0, seed) & mask;
      exp_r[f] = pat(f, 1, seed) & mask;
    end
    rx_idx = 0;
    if (hold) out_ready = 1'b0;
    left_lv = fmt ? 1'b0 : 1'b1;
    repeat (3) send_slot(~left_lv, 1'b1);
    for (int f = 0; f < nfr; f++) begin
      for (int h = 0; h < 2; h++) begin
        lv = h ? ~left_lv : left_lv;
        w  = pat(f, h, seed);
        for (int p = 0; p < slots; p++) begin
          if (!fmt) b = (p < 24) ? w[23-p] : p[0];
          else      b = (p == 0) ? 1'b1 : ((p <= 24) ? w[24-p] : p[0]);
          send_slot(lv, b);
        end
      end
    end
    repeat (3) send_slot(left_lv, 1'b1);
    repeat (20) step();
    if (hold) begin
      check(out_valid == 1'b1, "R8 held valid", out_valid, 1);
      check(rx_idx == 0, "R8 nothing taken", rx_idx, 0);
      out_ready = 1'b1;
      repeat (4) step();
      check(rx_idx == 1, "R8 newer pair dropped", rx_idx, 1);
    end else begin
      check(rx_idx == nfr, {"R7 pair count ", req}, rx_idx, nfr);
    end
    check(out_valid == 1'b0, "R9 valid cleared", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) step();
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_left == 24'h0, "R1 left in reset", out_left, 0);
    rst_n = 1'b1;
    step();
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    check(out_right == 24'h0, "R1 right after reset", out_right, 0);

    run_seq(1'b0, 24, 4, 1, 1'b0, "R2 R3 slot24");
    run_seq(1'b0, 32, 4, 2, 1'b0, "R3 R5 slot32");
    run_seq(1'b0, 25, 4, 3, 1'b0, "R3 R5 slot25");
    run_seq(1'b0, 20, 4, 4, 1'b0, "R3 R6 slot20");
    run_seq(1'b1, 32, 4, 5, 1'b0, "R2 R4 slot32");
    run_seq(1'b1, 25, 4, 6, 1'b0, "R4 R5 slot25");
    run_seq(1'b1, 24, 4, 7, 1'b0, "R4 R6 slot24");
    run_seq(1'b1, 20, 4, 8, 1'b0, "R4 R6 slot20");
    run_seq(1'b0, 32, 3, 9, 1'b1, "R8 hold");
    run_seq(1'b1, 32, 3, 10, 1'b1, "R8 hold i2s");

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule